// File: doc/BRIEF.md
# Speed-Mode PHY Configuration Controller

This block sits between a storage-card host controller and its I/O PHY. When the host settles on a new bus speed mode, clock rate or bus width, it pulses `apply_i`. The block then walks a fixed sequence of steps that set the PHY mode bits. These bits are the slow-mode bypass, the SDIO mode, the per-line and command DDR enables, asynchronous data sampling, the pad impedance codes and the strobe handling.

During this sequence the block gates the card clock while the DDR and sampling controls change. It finishes by starting the external PHY initialization sequencer and waiting for that sequencer's completion. Legacy mode and any configuration that lands in slow mode take a short path: they go straight from the mode step to initialization.

The block keeps a record of the last applied mode, clock class and bus width. A repeated request is dropped. A request made while the card clock is off clears the record and starts nothing.

Top module: `phy_mode_cfg`

## Requirements
- R1: After reset, `slow_mode_o`, `sdio_mode_o`, `dq_ddr_o`, `cmd_ddr_o`, `dq_async_o`, `strobe_dis_o`, `timing_load_o` and `init_start_o` are 0, `card_clk_en_o` is 1, and both impedance codes equal PAD_DEF (default 15).
- R2: Mode codes are: 0 legacy, 1 MMC high-speed, 2 SD high-speed, 3 SDR12, 4 SDR25, 5 SDR50, 6 SDR104, 7 DDR50, 8 DDR52, 9 HS200, 10 HS400. Slow mode is cleared whenever `clk_hi_i` was 1. Otherwise, in mode 0 it equals `slow_strap_i`. In modes 1 to 4 it equals `sdio_card_i | slow_strap_i`. In every other mode it is 0.
- R3: For every non-legacy mode, `sdio_mode_o` takes `sdio_card_i`. In legacy mode it keeps its previous value.
- R4: In legacy mode, or when slow mode ends up set, the block skips the pad, clock-gate, function and strobe steps. The impedance codes, DDR bits, async bit and `strobe_dis_o` then keep their values, and `card_clk_en_o` stays 1.
- R5: In mode 10, all `dq_ddr_o` bits and `cmd_ddr_o` are 1 and `dq_async_o` is 0. In modes 7 and 8, all DDR bits and `dq_async_o` are 1. In every other mode on the full path, the DDR bits are 0 and `dq_async_o` is 1.
- R6: On the full path, `card_clk_en_o` drops for exactly two cycles. The DDR and async outputs change only while it is low, and it returns to 1 afterwards.
- R7: On the full path, `znr_o` and `zpr_o` load `znr_i` and `zpr_i`.
- R8: On the full path in mode 10, `timing_load_o` pulses for one cycle with `timing_val_o` equal to LOGIC_TIMING, and `strobe_dis_o` is cleared. In any other mode on the full path, `strobe_dis_o` is set and no load pulse occurs.
- R9: Each accepted request ends in exactly one single-cycle `init_start_o` pulse. The block then waits for `init_done_i`, and `apply_i` is ignored until that wait is over.
- R10: A request whose mode, `clk_hi_i` and `bus_width_i` all match the last accepted request is ignored, with no pulse and no output change.
- R11: A request made with `clk_on_i` low starts nothing and changes no output. It also forgets the record, so the next request is accepted even if it matches the old one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| apply_i | input | 1 | Request to apply the presented configuration |
| mode_i | input | 4 | Speed-mode code |
| bus_width_i | input | 2 | Bus width code, used only for change detection |
| clk_on_i | input | 1 | Card clock is running |
| clk_hi_i | input | 1 | Card clock is above 52 MHz |
| sdio_card_i | input | 1 | Attached card is SDIO |
| slow_strap_i | input | 1 | Board requests slow mode |
| znr_i | input | 5 | N-side pad impedance code to load |
| zpr_i | input | 5 | P-side pad impedance code to load |
| init_done_i | input | 1 | PHY initialization sequencer finished |
| slow_mode_o | output | 1 | PHY slow-mode bypass |
| sdio_mode_o | output | 1 | PHY SDIO mode |
| dq_ddr_o | output | 8 | Per-data-line DDR enables |
| cmd_ddr_o | output | 1 | Command line DDR enable |
| dq_async_o | output | 1 | Asynchronous data sampling |
| znr_o | output | 5 | N-side pad impedance code |
| zpr_o | output | 5 | P-side pad impedance code |
| card_clk_en_o | output | 1 | Card clock enable |
| strobe_dis_o | output | 1 | Data/response strobe disabled |
| timing_load_o | output | 1 | Pulse to load the logic timing constant |
| timing_val_o | output | 32 | Logic timing constant |
| init_start_o | output | 1 | Pulse starting PHY initialization |

## Verification
Some properties hold on every cycle, and the assertions check those continuously. They cover the following: the DDR enables change only inside the gated-clock window, and that window lasts exactly two cycles. The initialization and timing-load outputs are single-cycle pulses, with the load pulse always paired with a cleared strobe-disable. No function-control change happens while slow mode is set. The initialization pulse never fires with the card clock gated.

Other behaviour depends on what was requested and on history, so only the bench scenarios can show it. This covers the mode-by-mode decision tree for slow, SDIO, DDR and async, and the retention of values on the short path. It also covers the dropping of duplicate requests, of requests made during the initialization wait, and of requests made with the clock off.

// File: rtl/phy_mode_cfg.sv
module phy_mode_cfg #(
  parameter int DQ_W = 8,
  parameter int IMP_W = 5,
  parameter int MODE_W = 4,
  parameter int BW_W = 2,
  parameter int TV_W = 32,
  parameter logic [IMP_W-1:0] PAD_DEF = 15,
  parameter logic [TV_W-1:0] LOGIC_TIMING = 32'h0055_3A61
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              apply_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [BW_W-1:0]   bus_width_i,
  input  logic              clk_on_i,
  input  logic              clk_hi_i,
  input  logic              sdio_card_i,
  input  logic              slow_strap_i,
  input  logic [IMP_W-1:0]  znr_i,
  input  logic [IMP_W-1:0]  zpr_i,
  input  logic              init_done_i,
  output logic              slow_mode_o,
  output logic              sdio_mode_o,
  output logic [DQ_W-1:0]   dq_ddr_o,
  output logic              cmd_ddr_o,
  output logic              dq_async_o,
  output logic [IMP_W-1:0]  znr_o,
  output logic [IMP_W-1:0]  zpr_o,
  output logic              card_clk_en_o,
  output logic              strobe_dis_o,
  output logic              timing_load_o,
  output logic [TV_W-1:0]   timing_val_o,
  output logic              init_start_o
);

  localparam logic [MODE_W-1:0] M_LEGACY = MODE_W'(0);
  localparam logic [MODE_W-1:0] M_MMCHS  = MODE_W'(1);
  localparam logic [MODE_W-1:0] M_SDHS   = MODE_W'(2);
  localparam logic [MODE_W-1:0] M_SDR12  = MODE_W'(3);
  localparam logic [MODE_W-1:0] M_SDR25  = MODE_W'(4);
  localparam logic [MODE_W-1:0] M_DDR50  = MODE_W'(7);
  localparam logic [MODE_W-1:0] M_DDR52  = MODE_W'(8);
  localparam logic [MODE_W-1:0] M_HS400  = MODE_W'(10);

  typedef enum logic [3:0] {
    ST_IDLE, ST_MODE, ST_PAD, ST_GATE, ST_FUNC, ST_UNGATE, ST_TAIL, ST_INIT, ST_WAIT
  } step_t;

  step_t             step_q;
  logic [MODE_W-1:0] req_mode_q, rec_mode_q;
  logic [BW_W-1:0]   rec_bw_q;
  logic              req_sdio_q, req_strap_q, req_hi_q;
  logic              rec_hi_q, rec_valid_q;
  logic [IMP_W-1:0]  znr_q, zpr_q;
  logic [DQ_W-1:0]   dq_ddr_q;
  logic              slow_q, sdio_q, cmd_ddr_q, async_q, clk_en_q, sdis_q, load_q, start_q;

  logic same_req, accept, forget, low_speed, is_legacy, is_ddr, is_hs400, slow_next;

  assign same_req  = rec_valid_q && (mode_i == rec_mode_q) && (clk_hi_i == rec_hi_q)
                     && (bus_width_i == rec_bw_q);
  assign accept    = (step_q == ST_IDLE) && apply_i && clk_on_i && !same_req;
  assign forget    = (step_q == ST_IDLE) && apply_i && !clk_on_i;

  assign is_legacy = (req_mode_q == M_LEGACY);
  assign is_hs400  = (req_mode_q == M_HS400);
  assign is_ddr    = (req_mode_q == M_DDR50) || (req_mode_q == M_DDR52);
  assign low_speed = (req_mode_q == M_MMCHS) || (req_mode_q == M_SDHS) ||
                     (req_mode_q == M_SDR12) || (req_mode_q == M_SDR25);
  assign slow_next = !req_hi_q && (is_legacy ? req_strap_q
                                             : (low_speed && (req_sdio_q || req_strap_q)));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      step_q      <= ST_IDLE;
      req_mode_q  <= '0;
      req_sdio_q  <= 1'b0;
      req_strap_q <= 1'b0;
      req_hi_q    <= 1'b0;
      rec_mode_q  <= '0;
      rec_bw_q    <= '0;
      rec_hi_q    <= 1'b0;
      rec_valid_q <= 1'b0;
    end else begin
      if (forget) rec_valid_q <= 1'b0;
      if (accept) begin
        req_mode_q  <= mode_i;
        req_sdio_q  <= sdio_card_i;
        req_strap_q <= slow_strap_i;
        req_hi_q    <= clk_hi_i;
        rec_mode_q  <= mode_i;
        rec_bw_q    <= bus_width_i;
        rec_hi_q    <= clk_hi_i;
        rec_valid_q <= 1'b1;
      end
      case (step_q)
        ST_IDLE:   if (accept) step_q <= ST_MODE;
        ST_MODE:   step_q <= (is_legacy || slow_next) ? ST_INIT : ST_PAD;
        ST_PAD:    step_q <= ST_GATE;
        ST_GATE:   step_q <= ST_FUNC;
        ST_FUNC:   step_q <= ST_UNGATE;
        ST_UNGATE: step_q <= ST_TAIL;
        ST_TAIL:   step_q <= ST_INIT;
        ST_INIT:   step_q <= ST_WAIT;
        ST_WAIT:   if (init_done_i) step_q <= ST_IDLE;
        default:   step_q <= ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slow_q    <= 1'b0;
      sdio_q    <= 1'b0;
      dq_ddr_q  <= '0;
      cmd_ddr_q <= 1'b0;
      async_q   <= 1'b0;
      znr_q     <= PAD_DEF;
      zpr_q     <= PAD_DEF;
      clk_en_q  <= 1'b1;
      sdis_q    <= 1'b0;
      load_q    <= 1'b0;
      start_q   <= 1'b0;
    end else begin
      load_q  <= 1'b0;
      start_q <= 1'b0;
      case (step_q)
        ST_MODE: begin
          slow_q <= slow_next;
          if (!is_legacy) sdio_q <= req_sdio_q;
        end
        ST_PAD: begin
          znr_q <= znr_i;
          zpr_q <= zpr_i;
        end
        ST_GATE:   clk_en_q <= 1'b0;
        ST_FUNC: begin
          dq_ddr_q  <= {DQ_W{is_hs400 || is_ddr}};
          cmd_ddr_q <= is_hs400 || is_ddr;
          async_q   <= !is_hs400;
        end
        ST_UNGATE: clk_en_q <= 1'b1;
        ST_TAIL: begin
          load_q <= is_hs400;
          sdis_q <= !is_hs400;
        end
        ST_INIT:   start_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign slow_mode_o   = slow_q;
  assign sdio_mode_o   = sdio_q;
  assign dq_ddr_o      = dq_ddr_q;
  assign cmd_ddr_o     = cmd_ddr_q;
  assign dq_async_o    = async_q;
  assign znr_o         = znr_q;
  assign zpr_o         = zpr_q;
  assign card_clk_en_o = clk_en_q;
  assign strobe_dis_o  = sdis_q;
  assign timing_load_o = load_q;
  assign timing_val_o  = LOGIC_TIMING;
  assign init_start_o  = start_q;

endmodule

// File: rtl/phy_mode_cfg_chk.sv
module phy_mode_cfg_chk #(
  parameter int DQ_W = 8
) (
  input logic            clk,
  input logic            rst_n,
  input logic            slow_mode_o,
  input logic [DQ_W-1:0] dq_ddr_o,
  input logic            cmd_ddr_o,
  input logic            dq_async_o,
  input logic            card_clk_en_o,
  input logic            strobe_dis_o,
  input logic            timing_load_o,
  input logic            init_start_o
);

  // R6
  ddr_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dq_ddr_o) |-> !card_clk_en_o && $past(!card_clk_en_o));

  // R6
  async_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(dq_async_o) |-> !card_clk_en_o);

  // R6
  gate_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(card_clk_en_o) |=> !card_clk_en_o ##1 card_clk_en_o);

  // R4
  slow_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slow_mode_o |-> $stable(dq_ddr_o) && $stable(cmd_ddr_o) && card_clk_en_o);

  // R5
  ddr_uniform_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (dq_ddr_o == {DQ_W{cmd_ddr_o}}) || !card_clk_en_o);

  // R8
  load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    timing_load_o |-> !strobe_dis_o ##1 !timing_load_o);

  // R9
  init_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    init_start_o |-> card_clk_en_o ##1 !init_start_o);

endmodule

bind phy_mode_cfg phy_mode_cfg_chk #(.DQ_W(DQ_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .slow_mode_o(slow_mode_o), .dq_ddr_o(dq_ddr_o),
  .cmd_ddr_o(cmd_ddr_o), .dq_async_o(dq_async_o), .card_clk_en_o(card_clk_en_o),
  .strobe_dis_o(strobe_dis_o), .timing_load_o(timing_load_o), .init_start_o(init_start_o)
);

// File: tb/phy_mode_cfg_tb.sv
`timescale 1ns/1ps
module phy_mode_cfg_tb_top;
  localparam logic [31:0] TV = 32'h0055_3A61;

  logic clk = 0, rst_n = 0;
  logic apply_i = 0, clk_on_i = 1, clk_hi_i = 0, sdio_card_i = 0, slow_strap_i = 0, init_done_i = 0;
  logic [3:0] mode_i = 0;
  logic [1:0] bus_width_i = 0;
  logic [4:0] znr_i = 0, zpr_i = 0;
  logic slow_mode_o, sdio_mode_o, cmd_ddr_o, dq_async_o, card_clk_en_o, strobe_dis_o;
  logic timing_load_o, init_start_o;
  logic [7:0] dq_ddr_o;
  logic [4:0] znr_o, zpr_o;
  logic [31:0] timing_val_o;

  phy_mode_cfg dut_i (.*);

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0, cycles = 0;
  int n_low = 0, n_init = 0, n_load = 0;
  logic [31:0] tv_seen = 0;

  always @(negedge clk) begin
    cycles++;
    if (!card_clk_en_o) n_low++;
    if (init_start_o) n_init++;
    if (timing_load_o) begin n_load++; tv_seen = timing_val_o; end
    if (cycles > 100000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected < 100000", cycles);
      $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic clr();
    n_low = 0; n_init = 0; n_load = 0; tv_seen = 0;
  endtask

  task automatic drive(input logic [3:0] m, input logic s, input logic st, input logic h,
                       input logic [1:0] bw, input logic con, input logic [4:0] zn, input logic [4:0] zp);
    @(negedge clk);
    mode_i = m; sdio_card_i = s; slow_strap_i = st; clk_hi_i = h;
    bus_width_i = bw; clk_on_i = con; znr_i = zn; zpr_i = zp; apply_i = 1;
    @(negedge clk);
    apply_i = 0;
  endtask

  task automatic wait_start();
    for (int k = 0; k < 30 && n_init == 0; k++) @(negedge clk);
  endtask

  task automatic finish_init();
    repeat (3) @(negedge clk);
    init_done_i = 1;
    @(negedge clk);
    init_done_i = 0;
    repeat (2) @(negedge clk);
  endtask

  // {mode, sdio, strap, hi, bw, slow, sdio_mode, full_path, ddr, async, load, strobe_dis}
  localparam logic [15:0] VEC [13] = '{
    {4'd10, 3'b001, 2'd2, 7'b0011010},
    {4'd8,  3'b000, 2'd2, 7'b0011101},
    {4'd4,  3'b100, 2'd1, 7'b1101101},
    {4'd4,  3'b101, 2'd1, 7'b0110101},
    {4'd0,  3'b010, 2'd0, 7'b1100101},
    {4'd0,  3'b001, 2'd0, 7'b0100101},
    {4'd1,  3'b010, 2'd2, 7'b1000101},
    {4'd2,  3'b000, 2'd1, 7'b0010101},
    {4'd7,  3'b110, 2'd2, 7'b0111101},
    {4'd10, 3'b111, 2'd2, 7'b0111010},
    {4'd3,  3'b010, 2'd0, 7'b1001000},
    {4'd9,  3'b011, 2'd2, 7'b0010101},
    {4'd6,  3'b010, 2'd2, 7'b0010101}
  };

  logic [4:0] exp_zn, exp_zp;

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 slow", slow_mode_o, 0);
    chk("R1 sdio", sdio_mode_o, 0);
    chk("R1 ddr", {dq_ddr_o, cmd_ddr_o, dq_async_o}, 0);
    chk("R1 clk_en", card_clk_en_o, 1);
    chk("R1 pulses", {strobe_dis_o, timing_load_o, init_start_o}, 0);
    chk("R1 znr", znr_o, 15);
    chk("R1 zpr", zpr_o, 15);
    rst_n = 1;
    exp_zn = 15; exp_zp = 15;

    for (int i = 0; i < 13; i++) begin
      logic [15:0] v;
      logic [4:0] zn, zp;
      v = VEC[i];
      zn = 5'(i * 3 + 1); zp = 5'(31 - i);
      clr();
      drive(v[15:12], v[11], v[10], v[9], v[8:7], 1'b1, zn, zp);
      wait_start();
      finish_init();
      if (v[4]) begin exp_zn = zn; exp_zp = zp; end
      chk($sformatf("R9 init pulse v%0d", i), n_init, 1);
      chk($sformatf("R2 slow v%0d", i), slow_mode_o, v[6]);
      chk($sformatf("R3 sdio v%0d", i), sdio_mode_o, v[5]);
      chk($sformatf("R5 dq v%0d", i), dq_ddr_o, {8{v[3]}});
      chk($sformatf("R5 cmd v%0d", i), cmd_ddr_o, v[3]);
      chk($sformatf("R5 async v%0d", i), dq_async_o, v[2]);
      chk($sformatf("R4 R6 gate cycles v%0d", i), n_low, v[4] ? 2 : 0);
      chk($sformatf("R6 clk restored v%0d", i), card_clk_en_o, 1);
      chk($sformatf("R7 znr v%0d", i), znr_o, exp_zn);
      chk($sformatf("R7 zpr v%0d", i), zpr_o, exp_zp);
      chk($sformatf("R8 load v%0d", i), n_load, (v[4] && v[1]) ? 1 : 0);
      chk($sformatf("R8 strobe_dis v%0d", i), strobe_dis_o, v[0]);
      if (v[1]) chk($sformatf("R8 value v%0d", i), tv_seen, TV);
    end

    // R10 duplicate of last (mode 6, hi 0, bw 2) is ignored even with other flags
    clr();
    drive(4'd6, 1'b1, 1'b1, 1'b0, 2'd2, 1'b1, 5'd3, 5'd3);
    repeat (20) @(negedge clk);
    chk("R10 no init", n_init, 0);
    chk("R10 sdio held", sdio_mode_o, 0);
    chk("R10 znr held", znr_o, exp_zn);

    // R11 clock off: nothing starts, then the same request is accepted
    clr();
    drive(4'd6, 1'b0, 1'b1, 1'b0, 2'd2, 1'b0, 5'd3, 5'd3);
    repeat (20) @(negedge clk);
    chk("R11 no init", n_init, 0);
    chk("R11 outputs held", {slow_mode_o, sdio_mode_o, dq_async_o, card_clk_en_o}, 4'b0011);
    clr();
    drive(4'd6, 1'b1, 1'b0, 1'b0, 2'd2, 1'b1, 5'd9, 5'd10);
    wait_start();
    finish_init();
    chk("R11 accepted after forget", n_init, 1);
    chk("R11 sdio now set", sdio_mode_o, 1);
    chk("R7 znr reload", znr_o, 9);

    // R9 apply during initialization wait is ignored
    clr();
    drive(4'd10, 1'b0, 1'b0, 1'b1, 2'd2, 1'b1, 5'd4, 5'd5);
    wait_start();
    drive(4'd8, 1'b0, 1'b0, 1'b1, 2'd1, 1'b1, 5'd6, 5'd7);
    finish_init();
    repeat (15) @(negedge clk);
    chk("R9 single init", n_init, 1);
    chk("R9 busy apply ignored async", dq_async_o, 0);
    chk("R9 busy apply ignored znr", znr_o, 4);
    chk("R8 hs400 strobe", strobe_dis_o, 0);

    // R2 high clock clears slow even with legacy strap
    clr();
    drive(4'd0, 1'b0, 1'b1, 1'b1, 2'd0, 1'b1, 5'd1, 5'd1);
    wait_start();
    finish_init();
    chk("R2 hi clears slow", slow_mode_o, 0);
    chk("R4 legacy no gate", n_low, 0);
    chk("R4 legacy keeps async", dq_async_o, 0);

    $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule